// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Cache Lookup

This block is the read lookup path of a 64 KiB, 4-way set-associative data cache with 64-byte lines (256 sets). The set is picked from untranslated virtual address bits. In the same cycle, an 8-entry fully associative translation buffer turns the 26-bit virtual page number of a 40-bit virtual address into an 18-bit physical frame number. With 16 KiB pages, the 6 line-offset bits and the 8 set-select bits both sit inside the 14-bit page offset. The set chosen from the virtual address is therefore the same set that the physical address would choose. The physical frame number serves directly as the stored tag.

Lookup takes two cycles. In the accept cycle the tag, valid and data arrays are read and the translation is done. In the next cycle the tags are compared and the 32-bit word is selected. One request can be accepted per cycle. When translation fails, the request is refused, and it is held upstream until a translation is written through the fill port. A cache miss returns the physical line address so that an outside agent can fetch the line. That agent then writes the whole line through the refill port, and a per-set tree pseudo-LRU chooses the way.

Top module: `vipt_cache`

## Requirements
- R1: After reset, no response is produced, every cache line is invalid and every translation entry is invalid. A request raised straight after reset therefore sees tlb_miss high and req_ready low.
- R2: Each accepted request (req_valid and req_ready high at a clock edge) produces exactly one response, with resp_valid high in the following cycle. Requests can be accepted in consecutive cycles. No response appears in a cycle that does not follow an acceptance.
- R3: The request address VA splits into a page number VA[39:14], a set number VA[13:6] and a word number VA[5:2]. resp_line equals the physical line address {PFN, VA[13:6]}, which is PA[31:6], so its low 8 bits equal the set number of the virtual address.
- R4: resp_hit is high only when exactly one way of the set is valid and its tag equals the translated PFN. resp_data is then bits [32*w+31 : 32*w] of the stored line, where w = VA[5:2]. Two virtual pages that map to the same PFN hit the same data, and a different PFN misses.
- R5: While req_valid is high and the page number is not held in the translation buffer, tlb_miss is high in that same cycle and req_ready is low.
- R6: A translation fill with a page number that is not yet held is written at a round-robin pointer. The pointer starts at entry 0 and wraps after 8 entries. A fill whose page number is already held overwrites that entry and leaves the pointer unchanged.
- R7: A refill writes the line into the way named by the set's 3-bit tree. Bit 0 chooses the pair (0: ways 0/1, 1: ways 2/3). Bit 1 chooses way 1 when set, else way 0. Bit 2 chooses way 3 when set, else way 2. Both hits and refills update the tree to point away from the way they used.
- R8: A refill of a line that is already present in its set overwrites that way, and no other way.
- R9: In any cycle where refill_valid is high, req_ready is low. A request held across the refill is accepted afterwards and sees the line that was just written.
- R10: When resp_valid is high, exactly one of resp_hit and resp_miss is high, and at most one way matches. When resp_valid is low, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Request accepted at this edge |
| req_va | input | 40 | Virtual byte address |
| tlb_fill_valid | input | 1 | Write a translation |
| tlb_fill_vpn | input | 26 | Virtual page number to write |
| tlb_fill_pfn | input | 18 | Physical frame number to write |
| refill_valid | input | 1 | Write a whole line |
| refill_line | input | 26 | Physical line address PA[31:6] of the refill |
| refill_data | input | 512 | Line contents, word w at bits [32w+31:32w] |
| tlb_miss | output | 1 | Current request has no translation |
| resp_valid | output | 1 | Response present |
| resp_hit | output | 1 | Response is a hit |
| resp_miss | output | 1 | Response is a miss |
| resp_data | output | 32 | Selected word on a hit |
| resp_line | output | 26 | Physical line address of the response |

## Verification
Two functions can fall in the same clock cycle: a line refill and the acceptance of a lookup. In a second case, a refill also coincides with the pseudo-LRU update made by a hit in the compare stage. The bench provokes the first case by holding a request to a set while it drives a refill of the very line that request wants. It judges the outcome by requiring req_ready to stay low in the refill cycle and the held request to hit with the new data afterwards. Replacement order is judged by observing which older line misses after a hit has moved the tree and a fifth line has been refilled into the same set.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    localparam int VA_W       = 40;
    localparam int PA_W       = 32;
    localparam int PAGE_BITS  = 14;
    localparam int LINE_BYTES = 64;
    localparam int WAYS       = 4;
    localparam int SETS       = 256;
    localparam int WORD_W     = 32;
    localparam int TLB_N      = 8;

    localparam int OFF_BITS   = $clog2(LINE_BYTES);
    localparam int IDX_BITS   = $clog2(SETS);
    localparam int VPN_W      = VA_W - PAGE_BITS;
    localparam int PFN_W      = PA_W - PAGE_BITS;
    localparam int LINE_W     = LINE_BYTES * 8;
    localparam int LADDR_W    = PA_W - OFF_BITS;
    localparam int WAY_BITS   = $clog2(WAYS);
    localparam int TREE_W     = WAYS - 1;
    localparam int TLB_BITS   = $clog2(TLB_N);
    localparam int BITPOS_W   = OFF_BITS + 3;

    typedef logic [VPN_W-1:0]     vpn_t;
    typedef logic [PFN_W-1:0]     pfn_t;
    typedef logic [IDX_BITS-1:0]  idx_t;
    typedef logic [LINE_W-1:0]    line_t;
    typedef logic [WAY_BITS-1:0]  way_t;
    typedef logic [LADDR_W-1:0]   laddr_t;
    typedef logic [PAGE_BITS-1:0] poff_t;
    typedef logic [TREE_W-1:0]    tree_t;
endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb
    import vipt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  vpn_t look_vpn,
    output logic look_hit,
    output pfn_t look_pfn,
    input  logic fill_valid,
    input  vpn_t fill_vpn,
    input  pfn_t fill_pfn
);
    typedef struct packed {
        logic [TLB_N-1:0]    vld;
        vpn_t [TLB_N-1:0]    vpn;
        pfn_t [TLB_N-1:0]    pfn;
        logic [TLB_BITS-1:0] ptr;
    } tlb_state_t;

    tlb_state_t st_q, st_d;
    logic                dup_hit;
    logic [TLB_BITS-1:0] dup_slot;

    // Lookup: fully associative, lowest matching entry wins
    always_comb begin
        look_hit = 1'b0;
        look_pfn = '0;
        for (int i = 0; i < TLB_N; i++) begin
            if (!look_hit && st_q.vld[i] && st_q.vpn[i] == look_vpn) begin
                look_hit = 1'b1;
                look_pfn = st_q.pfn[i];
            end
        end
    end

    // Fill: overwrite a held page in place, else take the round-robin slot
    always_comb begin
        dup_hit  = 1'b0;
        dup_slot = '0;
        for (int i = 0; i < TLB_N; i++) begin
            if (!dup_hit && st_q.vld[i] && st_q.vpn[i] == fill_vpn) begin
                dup_hit  = 1'b1;
                dup_slot = TLB_BITS'(i);
            end
        end
        st_d = st_q;
        if (fill_valid) begin
            if (dup_hit) begin
                st_d.pfn[dup_slot] = fill_pfn;
            end else begin
                st_d.vld[st_q.ptr] = 1'b1;
                st_d.vpn[st_q.ptr] = fill_vpn;
                st_d.pfn[st_q.ptr] = fill_pfn;
                st_d.ptr           = st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/vipt_way.sv
module vipt_way
    import vipt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rd_en,
    input  idx_t  rd_idx,
    output logic  rd_vld,
    output pfn_t  rd_tag,
    output line_t rd_data,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  pfn_t  wr_tag,
    input  line_t wr_data,
    output logic  pk_vld,
    output pfn_t  pk_tag
);
    logic [SETS-1:0] vld_q, vld_d;
    logic            rdv_q, rdv_d;
    pfn_t            tag_mem  [SETS];
    line_t           data_mem [SETS];
    pfn_t            rtag_q;
    line_t           rdat_q;

    always_comb begin
        vld_d = vld_q;
        if (wr_en) vld_d[wr_idx] = 1'b1;
        rdv_d = rdv_q;
        if (rd_en) rdv_d = vld_q[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            rdv_q <= 1'b0;
        end else begin
            vld_q <= vld_d;
            rdv_q <= rdv_d;
        end
    end

    // Array storage: no reset, validity lives in vld_q
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            data_mem[wr_idx] <= wr_data;
        end
        if (rd_en) begin
            rtag_q <= tag_mem[rd_idx];
            rdat_q <= data_mem[rd_idx];
        end
    end

    assign rd_vld  = rdv_q;
    assign rd_tag  = rtag_q;
    assign rd_data = rdat_q;
    assign pk_vld  = vld_q[wr_idx];
    assign pk_tag  = tag_mem[wr_idx];
endmodule

// File: rtl/vipt_plru.sv
module vipt_plru
    import vipt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  idx_t vic_idx,
    output way_t vic_way,
    input  logic hit_en,
    input  idx_t hit_idx,
    input  way_t hit_way,
    input  logic fill_en,
    input  idx_t fill_idx,
    input  way_t fill_way
);
    tree_t [SETS-1:0] st_q, st_d;

    // bit0: pair select, bit1: inside ways 0/1, bit2: inside ways 2/3
    function automatic way_t pick(input tree_t t);
        if (!t[0]) return t[1] ? way_t'(1) : way_t'(0);
        else       return t[2] ? way_t'(3) : way_t'(2);
    endfunction

    function automatic tree_t touch(input tree_t t, input way_t w);
        tree_t n = t;
        if (w < way_t'(2)) begin
            n[0] = 1'b1;
            n[1] = (w == way_t'(0));
        end else begin
            n[0] = 1'b0;
            n[2] = (w == way_t'(2));
        end
        return n;
    endfunction

    always_comb begin
        st_d = st_q;
        if (hit_en)  st_d[hit_idx]  = touch(st_d[hit_idx], hit_way);
        if (fill_en) st_d[fill_idx] = touch(st_d[fill_idx], fill_way);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vic_way = pick(st_q[vic_idx]);
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
    import vipt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_va,
    input  logic               tlb_fill_valid,
    input  logic [VPN_W-1:0]   tlb_fill_vpn,
    input  logic [PFN_W-1:0]   tlb_fill_pfn,
    input  logic               refill_valid,
    input  logic [LADDR_W-1:0] refill_line,
    input  logic [LINE_W-1:0]  refill_data,
    output logic               tlb_miss,
    output logic               resp_valid,
    output logic               resp_hit,
    output logic               resp_miss,
    output logic [WORD_W-1:0]  resp_data,
    output logic [LADDR_W-1:0] resp_line
);
    typedef struct packed {
        logic  vld;
        pfn_t  pfn;
        poff_t poff;
    } stage_t;

    stage_t s2_q, s2_d;

    vpn_t  req_vpn;
    poff_t req_poff;
    idx_t  req_idx;
    logic  tr_hit;
    pfn_t  tr_pfn;
    logic  accept;

    logic  [WAYS-1:0] rd_vld;
    pfn_t  [WAYS-1:0] rd_tag;
    line_t [WAYS-1:0] rd_data;
    logic  [WAYS-1:0] pk_vld;
    pfn_t  [WAYS-1:0] pk_tag;
    logic  [WAYS-1:0] wr_en;
    logic  [WAYS-1:0] way_match;

    logic  single;
    way_t  hit_way;
    line_t sel_line;
    logic  [BITPOS_W-1:0] bitpos;

    pfn_t  ref_tag;
    idx_t  ref_idx;
    logic  ref_dup;
    way_t  dup_way;
    way_t  vic_way;
    way_t  ref_way;

    assign req_vpn  = req_va[VA_W-1:PAGE_BITS];
    assign req_poff = req_va[PAGE_BITS-1:0];
    assign req_idx  = req_poff[OFF_BITS +: IDX_BITS];

    vipt_tlb u_tlb (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_vpn   (req_vpn),
        .look_hit   (tr_hit),
        .look_pfn   (tr_pfn),
        .fill_valid (tlb_fill_valid),
        .fill_vpn   (tlb_fill_vpn),
        .fill_pfn   (tlb_fill_pfn)
    );

    // Refill owns the arrays for its cycle; translation must succeed to go
    assign req_ready = tr_hit && !refill_valid;
    assign tlb_miss  = req_valid && !tr_hit;
    assign accept    = req_valid && req_ready;

    assign ref_tag = refill_line[LADDR_W-1 -: PFN_W];
    assign ref_idx = refill_line[IDX_BITS-1:0];

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            vipt_way u_way (
                .clk     (clk),
                .rst_n   (rst_n),
                .rd_en   (accept),
                .rd_idx  (req_idx),
                .rd_vld  (rd_vld[w]),
                .rd_tag  (rd_tag[w]),
                .rd_data (rd_data[w]),
                .wr_en   (wr_en[w]),
                .wr_idx  (ref_idx),
                .wr_tag  (ref_tag),
                .wr_data (refill_data),
                .pk_vld  (pk_vld[w]),
                .pk_tag  (pk_tag[w])
            );
            assign way_match[w] = rd_vld[w] && (rd_tag[w] == s2_q.pfn);
            assign wr_en[w]     = refill_valid && (ref_way == way_t'(w));
        end
    endgenerate

    vipt_plru u_plru (
        .clk      (clk),
        .rst_n    (rst_n),
        .vic_idx  (ref_idx),
        .vic_way  (vic_way),
        .hit_en   (resp_hit),
        .hit_idx  (s2_q.poff[OFF_BITS +: IDX_BITS]),
        .hit_way  (hit_way),
        .fill_en  (refill_valid),
        .fill_idx (ref_idx),
        .fill_way (ref_way)
    );

    // Refill way: in place if the line is already held, else the tree victim
    always_comb begin
        ref_dup = 1'b0;
        dup_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!ref_dup && pk_vld[w] && pk_tag[w] == ref_tag) begin
                ref_dup = 1'b1;
                dup_way = way_t'(w);
            end
        end
        ref_way = ref_dup ? dup_way : vic_way;
    end

    // Stage 2 compare and way select
    always_comb begin
        single   = (way_match != '0) && ((way_match & (way_match - 1'b1)) == '0);
        hit_way  = '0;
        sel_line = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_match[w]) begin
                hit_way  = way_t'(w);
                sel_line = sel_line | rd_data[w];
            end
        end
        bitpos = {s2_q.poff[OFF_BITS-1:0], 3'b000} & ~BITPOS_W'(WORD_W - 1);
    end

    assign resp_valid = s2_q.vld;
    assign resp_hit   = s2_q.vld && single;
    assign resp_miss  = s2_q.vld && !single;
    assign resp_data  = sel_line[bitpos +: WORD_W];
    assign resp_line  = {s2_q.pfn, s2_q.poff[PAGE_BITS-1:OFF_BITS]};

    always_comb begin
        s2_d      = s2_q;
        s2_d.vld  = accept;
        if (accept) begin
            s2_d.pfn  = tr_pfn;
            s2_d.poff = req_poff;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s2_q <= '0;
        else        s2_q <= s2_d;
    end
endmodule

// File: rtl/vipt_cache_chk.sv
module vipt_cache_chk
    import vipt_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [IDX_BITS-1:0] req_idx,
    input logic            refill_valid,
    input logic            tlb_miss,
    input logic            resp_valid,
    input logic            resp_hit,
    input logic            resp_miss,
    input logic [IDX_BITS-1:0] resp_idx,
    input logic [WAYS-1:0] way_match
);
    AST_ONE_WAY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $countones(way_match) <= 1); // R10

    AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_hit ^ resp_miss)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> (!resp_hit && !resp_miss)); // R10

    AST_HIT_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> $countones(way_match) == 1); // R4

    AST_RESP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> resp_valid); // R2

    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !resp_valid); // R2

    AST_SET_FROM_VA: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> resp_idx == $past(req_idx)); // R3

    AST_REFILL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        refill_valid |-> !req_ready); // R9

    AST_TLB_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_miss |-> !req_ready); // R5
endmodule

bind vipt_cache vipt_cache_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_idx      (req_va[vipt_pkg::OFF_BITS +: vipt_pkg::IDX_BITS]),
    .refill_valid (refill_valid),
    .tlb_miss     (tlb_miss),
    .resp_valid   (resp_valid),
    .resp_hit     (resp_hit),
    .resp_miss    (resp_miss),
    .resp_idx     (resp_line[vipt_pkg::IDX_BITS-1:0]),
    .way_match    (way_match)
);

// File: tb/sim_vipt_cache.sv
`timescale 1ns/1ps
module sim_vipt_cache;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [39:0]  req_va = '0;
    logic         tlb_fill_valid = 1'b0;
    logic [25:0]  tlb_fill_vpn = '0;
    logic [17:0]  tlb_fill_pfn = '0;
    logic         refill_valid = 1'b0;
    logic [25:0]  refill_line = '0;
    logic [511:0] refill_data = '0;
    logic         tlb_miss, resp_valid, resp_hit, resp_miss;
    logic [31:0]  resp_data;
    logic [25:0]  resp_line;

    always #2 clk = ~clk;   // 250 MHz

    vipt_cache u0 (.*);

    typedef struct {
        bit          hit;
        logic [31:0] data;
        logic [25:0] line;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    localparam logic [17:0] PA = 18'h0000A, PB = 18'h0000B, PC = 18'h0000C,
                            PD = 18'h0000D, PE = 18'h0000E;

    function automatic logic [39:0] mkva(input logic [25:0] vpn, input logic [7:0] idx,
                                         input logic [3:0] w);
        return {vpn, idx, w, 2'b00};
    endfunction

    function automatic logic [25:0] mkline(input logic [17:0] pfn, input logic [7:0] idx);
        return {pfn, idx};
    endfunction

    function automatic logic [31:0] mkword(input logic [25:0] line, input logic [3:0] w,
                                           input logic [1:0] salt);
        return {salt, w, line};
    endfunction

    function automatic logic [511:0] mkdata(input logic [25:0] line, input logic [1:0] salt);
        logic [511:0] d;
        for (int w = 0; w < 16; w++) d[32*w +: 32] = mkword(line, 4'(w), salt);
        return d;
    endfunction

    task automatic chk(input string r, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    // Monitor: pops one expected item per response
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (q.size() == 0) begin
                chk("R2", "response with nothing pending", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, "hit", 64'(resp_hit), 64'(e.hit));
                chk("R10", "miss flag", 64'(resp_miss), 64'(!e.hit));
                chk("R3", "line address", 64'(resp_line), 64'(e.line));
                if (e.hit) chk(e.tag, "data", 64'(resp_data), 64'(e.data));
            end
        end
    end

    task automatic tlb_fill(input logic [25:0] vpn, input logic [17:0] pfn);
        tlb_fill_valid = 1'b1; tlb_fill_vpn = vpn; tlb_fill_pfn = pfn;
        @(posedge clk); #1;
        tlb_fill_valid = 1'b0;
    endtask

    task automatic refill(input logic [25:0] line, input logic [1:0] salt);
        refill_valid = 1'b1; refill_line = line; refill_data = mkdata(line, salt);
        @(posedge clk); #1;
        refill_valid = 1'b0;
    endtask

    // Driver: pushes the expected item when the request is taken
    task automatic lookup(input logic [39:0] va, input bit hit, input logic [1:0] salt,
                          input logic [17:0] pfn, input string tag);
        exp_t e;
        req_valid = 1'b1; req_va = va;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        e.hit  = hit;
        e.line = mkline(pfn, va[13:6]);
        e.data = mkword(e.line, va[5:2], salt);
        e.tag  = tag;
        q.push_back(e);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (3) @(posedge clk);
        #1;
        chk("R2", "pending responses", 64'(q.size()), 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "resp_valid after reset", 64'(resp_valid), 64'd0);
        chk("R1", "tlb_miss idle", 64'(tlb_miss), 64'd0);
        @(posedge clk); #1;
        req_valid = 1'b1; req_va = mkva(26'h100, 8'd5, 4'd0);
        @(negedge clk);
        chk("R1", "empty translation buffer misses", 64'(tlb_miss), 64'd1);
        chk("R5", "ready low on translation miss", 64'(req_ready), 64'd0);
        @(posedge clk); #1;
        req_valid = 1'b0;

        tlb_fill(26'h100, PA);
        tlb_fill(26'h200, PB);
        tlb_fill(26'h300, PA);
        tlb_fill(26'h400, PE);
        tlb_fill(26'h500, PC);

        // R1 empty cache, R3 line address on miss
        lookup(mkva(26'h100, 8'd5, 4'd3), 1'b0, 2'd0, PA, "R1");
        drain();
        refill(mkline(PA, 8'd5), 2'd0);
        lookup(mkva(26'h100, 8'd5, 4'd3), 1'b1, 2'd0, PA, "R4");
        lookup(mkva(26'h100, 8'd5, 4'd15), 1'b1, 2'd0, PA, "R4");
        // R4 physical tag: other frame misses, alias page hits
        lookup(mkva(26'h200, 8'd5, 4'd1), 1'b0, 2'd0, PB, "R4");
        lookup(mkva(26'h300, 8'd5, 4'd9), 1'b1, 2'd0, PA, "R4");
        drain();

        // R7 replacement: fill ways 2,1,3, hit way 0, fifth line evicts way 2
        refill(mkline(PB, 8'd5), 2'd0);
        refill(mkline(PC, 8'd5), 2'd0);
        refill(mkline(PD, 8'd5), 2'd0);
        lookup(mkva(26'h100, 8'd5, 4'd4), 1'b1, 2'd0, PA, "R7");
        drain();
        refill(mkline(PE, 8'd5), 2'd0);
        lookup(mkva(26'h200, 8'd5, 4'd0), 1'b0, 2'd0, PB, "R7");
        lookup(mkva(26'h100, 8'd5, 4'd6), 1'b1, 2'd0, PA, "R7");
        lookup(mkva(26'h400, 8'd5, 4'd2), 1'b1, 2'd0, PE, "R7");
        lookup(mkva(26'h500, 8'd5, 4'd8), 1'b1, 2'd0, PC, "R7");
        drain();

        // R8 refill of a held line stays in its way
        refill(mkline(PA, 8'd5), 2'd1);
        lookup(mkva(26'h100, 8'd5, 4'd2), 1'b1, 2'd1, PA, "R8");
        lookup(mkva(26'h500, 8'd5, 4'd11), 1'b1, 2'd0, PC, "R8");
        lookup(mkva(26'h400, 8'd5, 4'd12), 1'b1, 2'd0, PE, "R8");
        drain();

        // R9 refill and request in the same cycle
        req_valid = 1'b1; req_va = mkva(26'h100, 8'd9, 4'd7);
        refill_valid = 1'b1; refill_line = mkline(PA, 8'd9); refill_data = mkdata(mkline(PA, 8'd9), 2'd2);
        @(negedge clk);
        chk("R9", "ready low during refill", 64'(req_ready), 64'd0);
        chk("R9", "translation still hits", 64'(tlb_miss), 64'd0);
        @(posedge clk); #1;
        refill_valid = 1'b0;
        lookup(mkva(26'h100, 8'd9, 4'd7), 1'b1, 2'd2, PA, "R9");

        // R2 back-to-back acceptance
        lookup(mkva(26'h100, 8'd5, 4'd0), 1'b1, 2'd1, PA, "R2");
        lookup(mkva(26'h300, 8'd9, 4'd1), 1'b1, 2'd2, PA, "R2");
        lookup(mkva(26'h200, 8'd5, 4'd5), 1'b0, 2'd0, PB, "R2");
        lookup(mkva(26'h400, 8'd5, 4'd15), 1'b1, 2'd0, PE, "R2");
        drain();

        // R5 held request across translation misses, then fill
        req_valid = 1'b1; req_va = mkva(26'h777, 8'd5, 4'd3);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R5", "tlb_miss while held", 64'(tlb_miss), 64'd1);
            chk("R5", "ready low while held", 64'(req_ready), 64'd0);
        end
        @(posedge clk); #1;
        tlb_fill(26'h777, PA);
        lookup(mkva(26'h777, 8'd5, 4'd3), 1'b1, 2'd1, PA, "R5");
        drain();

        // R6 round robin: entries 6,7 then wrap onto entry 0
        tlb_fill(26'h801, PB);
        tlb_fill(26'h802, PB);
        tlb_fill(26'h803, PB);
        req_valid = 1'b1; req_va = mkva(26'h100, 8'd5, 4'd0);
        @(negedge clk);
        chk("R6", "entry 0 replaced on wrap", 64'(tlb_miss), 64'd1);
        @(posedge clk); #1;
        req_valid = 1'b0;
        lookup(mkva(26'h300, 8'd5, 4'd1), 1'b1, 2'd1, PA, "R6");
        // held page refilled in place, pointer stays at entry 1
        tlb_fill(26'h200, PA);
        lookup(mkva(26'h200, 8'd5, 4'd4), 1'b1, 2'd1, PA, "R6");
        tlb_fill(26'h804, PB);
        req_valid = 1'b1; req_va = mkva(26'h200, 8'd5, 4'd0);
        @(negedge clk);
        chk("R6", "entry 1 replaced after in-place fill", 64'(tlb_miss), 64'd1);
        @(posedge clk); #1;
        req_valid = 1'b0;
        lookup(mkva(26'h300, 8'd5, 4'd13), 1'b1, 2'd1, PA, "R6");
        drain();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule